// File: doc/BRIEF.md
# Spread-Spectrum Differential QPSK IF Transmitter

This block turns a serial bit stream into a stream of signed digital IF samples, one per clock. Bits arrive through a ready/valid handshake and are paired into dibits. Each dibit selects a quarter-turn phase step, which is added to a running phase. The phase then picks signs for the in-phase and quadrature rails. Because the data rides on phase changes rather than absolute phase, a receiver that locks with a 90-degree-multiple offset still decodes correctly.

Each symbol is spread by an 11-chip Barker sequence. Each chip lasts four samples, so one symbol is 44 samples long. The chips are mixed onto a carrier at one quarter of the sample rate. Over each group of four samples the cosine runs +1, 0, -1, 0 and the sine runs 0, +1, 0, -1. This reduces the mixer to sign selection: no multipliers and no table. A one-cycle strobe marks the first sample of every symbol. The output is zero whenever no symbol is in flight.

Top module: `dsss_dqpsk_tx`

## Requirements
- R1: While reset is held, and on the first cycle after it, `if_sample` is 0, `sym_strobe` is 0 and `bit_ready` is 1.
- R2: A bit is taken on a rising edge where `bit_valid` and `bit_ready` are both high. The first bit of a pair is the dibit MSB and the second is the LSB.
- R3: Once two bits are held and not yet consumed, `bit_ready` stays low. Bits offered while `bit_ready` or `bit_valid` is low are not taken.
- R4: A phase register (reset value 0, modulo 4 quarter turns) advances per symbol by a Gray step: dibit 00 adds 0, 01 adds 1, 11 adds 2, 10 adds 3. Phase 0 gives rails (I,Q)=(+,+), 1 gives (-,+), 2 gives (-,-) and 3 gives (+,-). The phase changes only when a symbol starts.
- R5: Chip c (0..10) of a symbol covers samples 4c to 4c+3 and uses the Barker value at index c, from +1 +1 +1 -1 -1 -1 +1 -1 -1 +1 -1.
- R6: At sample position n within a chip, with Barker value b, the output is +I·b for n=0, -Q·b for n=1, -I·b for n=2 and +Q·b for n=3. A value of +1 maps to +AMPLITUDE (31) and -1 maps to -31. No other nonzero value appears.
- R7: `sym_strobe` is high for exactly one cycle, together with the first sample of each symbol. A symbol lasts 44 samples. If a full dibit is waiting when a symbol ends, the next symbol follows with no gap.
- R8: While no symbol is in progress, `if_sample` is 0.
- R9: Starting from idle, the strobe and the first sample appear on the second rising edge after the edge that takes the second bit of a dibit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_in | input | 1 | Serial data bit |
| bit_valid | input | 1 | `bit_in` is valid |
| bit_ready | output | 1 | Block can take a bit |
| sym_strobe | output | 1 | First sample of a symbol is on `if_sample` |
| if_sample | output | SAMPLE_W (6) | Signed IF sample, two's complement |

## Verification
The hardest case to reach from the ports is the hand-over between symbols. The buffer must hold a complete dibit at the exact moment the 44th sample leaves, so that the next symbol starts with no gap and the phase steps exactly once. The stimulus fills the buffer early in each symbol and then keeps `bit_valid` high with junk bits while `bit_ready` is low. Any bit taken early, or any slip at the boundary, then shows up as wrong signs in the sample stream. Runs of back-to-back dibits cover all four phase steps and both orderings of the mixed dibits. An idle gap with toggling, unqualified inputs checks that nothing leaks out between bursts.

// File: rtl/dsss_tx_pkg.sv
package dsss_tx_pkg;

    localparam int CHIPS      = 11;
    localparam int SPC        = 4;
    localparam int SYM_LEN    = CHIPS * SPC;
    localparam int CHIP_W     = $clog2(CHIPS);
    localparam int SUB_W      = $clog2(SPC);

    typedef logic [1:0] phase_t;

    typedef struct packed {
        logic i_neg;
        logic q_neg;
    } rail_t;

    typedef struct packed {
        logic              active;
        logic [CHIP_W-1:0] chip;
        logic [SUB_W-1:0]  sub;
    } slot_t;

    // Barker spreading sign: 1 means the chip value is -1.
    function automatic logic barker_neg(input logic [CHIP_W-1:0] idx);
        logic r;
        case (idx)
            4'd3, 4'd4, 4'd5, 4'd7, 4'd8, 4'd10: r = 1'b1;
            default:                             r = 1'b0;
        endcase
        return r;
    endfunction

    // Gray-coded phase increment in quarter turns.
    function automatic phase_t gray_step(input logic [1:0] d);
        phase_t r;
        case (d)
            2'b00:   r = 2'd0;
            2'b01:   r = 2'd1;
            2'b11:   r = 2'd2;
            default: r = 2'd3;
        endcase
        return r;
    endfunction

    function automatic rail_t phase_rails(input phase_t p);
        rail_t r;
        r.i_neg = (p == 2'd1) || (p == 2'd2);
        r.q_neg = (p == 2'd2) || (p == 2'd3);
        return r;
    endfunction

endpackage

// File: rtl/tx_dibit_collect.sv
module tx_dibit_collect (
    input  logic       clk,
    input  logic       rst,
    input  logic       bit_in,
    input  logic       bit_valid,
    input  logic       take,
    output logic       bit_ready,
    output logic       full,
    output logic [1:0] dibit
);
    logic [1:0] cnt_q;
    logic [1:0] buf_q;
    logic       accept;

    assign bit_ready = (cnt_q != 2'd2);
    assign full      = (cnt_q == 2'd2);
    assign accept    = bit_valid && bit_ready;
    assign dibit     = buf_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= 2'd0;
            buf_q <= 2'b00;
        end else if (take) begin
            cnt_q <= 2'd0;
        end else if (accept) begin
            buf_q <= {buf_q[0], bit_in};
            cnt_q <= cnt_q + 2'd1;
        end
    end
endmodule

// File: rtl/tx_symbol_timer.sv
module tx_symbol_timer
    import dsss_tx_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  full,
    output logic  take,
    output slot_t slot
);
    slot_t slot_q;
    logic  last;

    assign last = slot_q.active
               && (slot_q.chip == CHIP_W'(CHIPS - 1))
               && (slot_q.sub  == SUB_W'(SPC - 1));
    assign take = full && (!slot_q.active || last);
    assign slot = slot_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= '0;
        end else if (take) begin
            slot_q.active <= 1'b1;
            slot_q.chip   <= '0;
            slot_q.sub    <= '0;
        end else if (last) begin
            slot_q <= '0;
        end else if (slot_q.active) begin
            slot_q.sub <= slot_q.sub + SUB_W'(1);
            if (slot_q.sub == SUB_W'(SPC - 1))
                slot_q.chip <= slot_q.chip + CHIP_W'(1);
        end
    end
endmodule

// File: rtl/tx_diff_enc.sv
module tx_diff_enc
    import dsss_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       take,
    input  logic [1:0] dibit,
    output phase_t     phase,
    output rail_t      rails
);
    phase_t phase_q;
    phase_t phase_n;
    rail_t  rails_q;

    assign phase_n = phase_q + gray_step(dibit);
    assign phase   = phase_q;
    assign rails   = rails_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
            rails_q <= '0;
        end else if (take) begin
            phase_q <= phase_n;
            rails_q <= phase_rails(phase_n);
        end
    end
endmodule

// File: rtl/tx_if_mixer.sv
module tx_if_mixer
    import dsss_tx_pkg::*;
#(
    parameter int SAMPLE_W  = 6,
    parameter int AMPLITUDE = 31
) (
    input  logic                       clk,
    input  logic                       rst,
    input  slot_t                      slot,
    input  rail_t                      rails,
    output logic signed [SAMPLE_W-1:0] if_sample,
    output logic                       sym_strobe
);
    localparam logic signed [SAMPLE_W-1:0] POS = SAMPLE_W'(AMPLITUDE);
    localparam logic signed [SAMPLE_W-1:0] NEG = -POS;

    logic rail_neg;
    logic neg;
    logic first;

    // Quarter-rate carrier: cos = +1,0,-1,0 ; sin = 0,+1,0,-1 ; out = I*cos - Q*sin
    always_comb begin
        case (slot.sub)
            2'd0:    rail_neg = rails.i_neg;
            2'd1:    rail_neg = ~rails.q_neg;
            2'd2:    rail_neg = ~rails.i_neg;
            default: rail_neg = rails.q_neg;
        endcase
    end

    assign neg   = rail_neg ^ barker_neg(slot.chip);
    assign first = slot.active && (slot.chip == '0) && (slot.sub == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            if_sample  <= '0;
            sym_strobe <= 1'b0;
        end else begin
            sym_strobe <= first;
            if (!slot.active) if_sample <= '0;
            else if (neg)     if_sample <= NEG;
            else              if_sample <= POS;
        end
    end
endmodule

// File: rtl/dsss_dqpsk_tx.sv
module dsss_dqpsk_tx
    import dsss_tx_pkg::*;
#(
    parameter int SAMPLE_W  = 6,
    parameter int AMPLITUDE = 31
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       bit_in,
    input  logic                       bit_valid,
    output logic                       bit_ready,
    output logic                       sym_strobe,
    output logic signed [SAMPLE_W-1:0] if_sample
);
    logic       take;
    logic       full;
    logic [1:0] dibit;
    slot_t      slot;
    phase_t     phase_q;
    rail_t      rails;

    tx_dibit_collect u_collect (
        .clk       (clk),
        .rst       (rst),
        .bit_in    (bit_in),
        .bit_valid (bit_valid),
        .take      (take),
        .bit_ready (bit_ready),
        .full      (full),
        .dibit     (dibit)
    );

    tx_symbol_timer u_timer (
        .clk  (clk),
        .rst  (rst),
        .full (full),
        .take (take),
        .slot (slot)
    );

    tx_diff_enc u_enc (
        .clk   (clk),
        .rst   (rst),
        .take  (take),
        .dibit (dibit),
        .phase (phase_q),
        .rails (rails)
    );

    tx_if_mixer #(
        .SAMPLE_W  (SAMPLE_W),
        .AMPLITUDE (AMPLITUDE)
    ) u_mixer (
        .clk        (clk),
        .rst        (rst),
        .slot       (slot),
        .rails      (rails),
        .if_sample  (if_sample),
        .sym_strobe (sym_strobe)
    );
endmodule

// File: rtl/dsss_dqpsk_tx_chk.sv
module dsss_dqpsk_tx_chk
    import dsss_tx_pkg::*;
#(
    parameter int SAMPLE_W  = 6,
    parameter int AMPLITUDE = 31
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       bit_ready,
    input logic                       sym_strobe,
    input logic signed [SAMPLE_W-1:0] if_sample,
    input logic                       take,
    input phase_t                     phase_q
);
    localparam logic signed [SAMPLE_W-1:0] POS = SAMPLE_W'(AMPLITUDE);
    localparam logic signed [SAMPLE_W-1:0] NEG = -POS;

    logic [6:0] since;
    logic       seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            since <= '0;
            seen  <= 1'b0;
        end else if (sym_strobe) begin
            since <= '0;
            seen  <= 1'b1;
        end else if (since != 7'h7f) begin
            since <= since + 7'd1;
        end
    end

    a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (if_sample == '0 && !sym_strobe && bit_ready));

    a_r7_strobe_spacing: assert property (@(posedge clk) disable iff (rst)
        (sym_strobe && seen) |-> (since >= 7'(SYM_LEN - 1)));

    a_r7_strobe_nonzero: assert property (@(posedge clk) disable iff (rst)
        sym_strobe |-> (if_sample != '0));

    a_r6_levels: assert property (@(posedge clk) disable iff (rst)
        (if_sample == '0) || (if_sample == POS) || (if_sample == NEG));

    a_r3_ready_hold: assert property (@(posedge clk) disable iff (rst)
        (!bit_ready && !take) |=> !bit_ready);

    a_r4_phase_hold: assert property (@(posedge clk) disable iff (rst)
        !take |=> $stable(phase_q));
endmodule

bind dsss_dqpsk_tx dsss_dqpsk_tx_chk #(
    .SAMPLE_W  (SAMPLE_W),
    .AMPLITUDE (AMPLITUDE)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bit_ready  (bit_ready),
    .sym_strobe (sym_strobe),
    .if_sample  (if_sample),
    .take       (take),
    .phase_q    (phase_q)
);

// File: tb/dsss_dqpsk_tx_bench.sv
module dsss_dqpsk_tx_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_in = 1'b0;
    logic bit_valid = 1'b0;
    logic bit_ready;
    logic sym_strobe;
    logic signed [5:0] if_sample;

    always #2 clk = ~clk;

    dsss_dqpsk_tx u_dsss_dqpsk_tx (
        .clk        (clk),
        .rst        (rst),
        .bit_in     (bit_in),
        .bit_valid  (bit_valid),
        .bit_ready  (bit_ready),
        .sym_strobe (sym_strobe),
        .if_sample  (if_sample)
    );

    int checks = 0;
    int errors = 0;
    int exp_q[$];
    int left = 0;
    int exp_phase = 0;
    bit done = 1'b0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // R5: Barker signs, 1 = -1
    function automatic bit bneg(input int c);
        bit [10:0] seq = 11'b10110111000; // bit c = index c
        return seq[c];
    endfunction

    // R4 Gray step
    function automatic int gstep(input bit a, input bit b);
        case ({a, b})
            2'b00:   return 0;
            2'b01:   return 1;
            2'b11:   return 2;
            default: return 3;
        endcase
    endfunction

    task automatic push_symbol(input bit a, input bit b);
        bit ineg, qneg, rn, n;
        exp_phase = (exp_phase + gstep(a, b)) % 4;
        ineg = (exp_phase == 1) || (exp_phase == 2);
        qneg = (exp_phase == 2) || (exp_phase == 3);
        for (int k = 0; k < 44; k++) begin
            case (k % 4)
                0:       rn = ineg;
                1:       rn = !qneg;
                2:       rn = !ineg;
                default: rn = qneg;
            endcase
            n = rn ^ bneg(k / 4);
            exp_q.push_back(n ? -31 : 31);
        end
    endtask

    task automatic send_bit(input bit b);
        bit_in = b;
        bit_valid = 1'b1;
        while (!bit_ready) @(negedge clk);
        @(negedge clk);
        bit_valid = 1'b0;
    endtask

    task automatic send_dibit(input bit a, input bit b);
        push_symbol(a, b);
        send_bit(a);
        send_bit(b);
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (sym_strobe) begin
                chk(left == 0, "R7 strobe spacing", left, 0);
                left = 44;
            end
            if (left > 0) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R7 unexpected symbol", int'(if_sample), 0);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    chk(int'(if_sample) == e, "R2 R4 R5 R6 sample", int'(if_sample), e);
                end
                left--;
            end else begin
                chk(if_sample == 0, "R8 idle output", int'(if_sample), 0);
            end
        end
    end

    initial begin
        #(4 * 200000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(if_sample == 0, "R1 sample", int'(if_sample), 0);
        chk(sym_strobe == 0, "R1 strobe", int'(sym_strobe), 0);
        chk(bit_ready == 1, "R1 ready", int'(bit_ready), 1);
        rst = 1'b0;
        @(negedge clk);
        chk(bit_ready == 1, "R1 ready after release", int'(bit_ready), 1);

        // R9 latency from idle
        send_dibit(1'b0, 1'b0);
        @(negedge clk);
        chk(sym_strobe == 0, "R9 strobe early", int'(sym_strobe), 0);
        @(negedge clk);
        chk(sym_strobe == 1, "R9 strobe on time", int'(sym_strobe), 1);

        // R3: buffer fills during a symbol, ready drops, junk is ignored
        send_dibit(1'b0, 1'b1);
        chk(bit_ready == 0, "R3 ready low when full", int'(bit_ready), 0);
        bit_in = 1'b1;
        bit_valid = 1'b1;
        repeat (6) begin
            @(negedge clk);
            chk(bit_ready == 0, "R3 ready held", int'(bit_ready), 0);
        end
        bit_valid = 1'b0;

        // back-to-back, all steps, both mixed orders (R2)
        send_dibit(1'b1, 1'b1);
        send_dibit(1'b1, 1'b0);
        send_dibit(1'b0, 1'b1);
        send_dibit(1'b1, 1'b0);

        // idle gap with unqualified toggling input (R3, R8)
        while (exp_q.size() != 0 || left != 0) @(negedge clk);
        repeat (30) begin
            @(negedge clk);
            bit_in = ~bit_in;
        end
        chk(if_sample == 0, "R8 idle after burst", int'(if_sample), 0);

        for (int i = 0; i < 8; i++)
            send_dibit(i[0], i[1] ^ i[2]);

        while (exp_q.size() != 0 || left != 0) @(negedge clk);
        repeat (20) @(negedge clk);
        done = 1'b1;
        chk(exp_q.size() == 0, "R7 all symbols emitted", exp_q.size(), 0);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule